// File: doc/BRIEF.md
# Dual-Mode Fault Status Register

This block is a single bus-visible status word that reports four fault lines belonging to one PWM generator. Each raw fault line is brought into the clock domain by a two-flop synchronizer. It is then XORed with its own invert bit, so that an active fault is always a logic 1 inside the block.

A mode bit selects what software reads. With the mode bit clear, the four flag bits show the adjusted fault levels as they are now, and they cannot be written. With the mode bit set, the flags are sticky: a flag rises once its adjusted line has been active and stays up until software writes a 1 to it. An extension-enable bit gates every write. When that bit is clear, a write never changes anything.

The sticky flags keep collecting faults while the mode bit is clear. A fault that is active when software switches to sticky mode is therefore already visible. The flags track every fault line, whether or not the generator uses that line as a fault source.

Top module: `fault_status_reg`

## Requirements
- R1: After reset, every bit of the read data is 0 and every sticky flag is clear.
- R2: Bits 31:4 of the read data always read 0, and any address other than the register address (default 0x04) reads 0.
- R3: With the mode bit clear, bit i of the read data (i = 0..3) equals the adjusted level of fault line i. A change on a raw line becomes visible after two rising clock edges.
- R4: The adjusted level of line i is the raw line XOR invert bit i. A change of an invert bit shows on the read data in the same cycle.
- R5: With the mode bit set, a flag becomes 1 one edge after its synchronized, adjusted line is active, and it stays 1 after the line goes inactive.
- R6: With the mode bit set and writes enabled, a write to the register address clears each flag whose write-data bit is 1. Write-data bits that are 0 leave their flags unchanged.
- R7: When the extension-enable bit is clear, no write changes any flag.
- R8: If a clearing write and an active adjusted line hit the same flag in the same cycle, the flag stays 1.
- R9: Flags keep capturing while the mode bit is clear. A fault seen in that time is read as 1 once the mode bit is set.
- R10: A write made while the mode bit is clear does not clear any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address for both read and write |
| wrData | input | 32 | Write data; bits 3:0 form the clear mask |
| wrEn | input | 1 | Write strobe |
| rdData | output | 32 | Combinational read data |
| faultRaw | input | 4 | Raw fault lines, asynchronous |
| faultInvert | input | 4 | Per-line sense invert bits |
| latchMode | input | 1 | 1 selects the sticky view, 0 the live view |
| extEnable | input | 1 | 1 allows writes to take effect |

## Verification
A clearing write and a newly active adjusted fault can land on the same flag in the same cycle. The bench provokes this by holding a fault line active, waiting until it has passed through the synchronizer, and then issuing a write-1 to that flag. It also clears a flag on the exact edge where a pulsed line first becomes active after synchronization. The behavioural model applies the clear before the set, so it expects the flag to stay 1. The read data is compared with the model after every edge.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef struct packed {
    logic addrHit;     // current address selects this register
    logic clrStrobe;   // accepted write-1-to-clear this cycle
    logic showSticky;  // read the sticky view instead of live levels
  } fsrCtrl_t;
endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h04
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              latchMode,
  input  logic              extEnable,
  output fsrCtrl_t          ctrl
);
  always_comb begin
    ctrl.addrHit    = (addr == REG_ADDR);
    ctrl.showSticky = latchMode;
    ctrl.clrStrobe  = wrEn && ctrl.addrHit && extEnable && latchMode;
  end
endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
#(
  parameter int NUM_FAULTS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_FAULTS-1:0] faultRaw,
  input  logic [NUM_FAULTS-1:0] faultInvert,
  input  logic [NUM_FAULTS-1:0] clrMask,
  input  fsrCtrl_t              ctrl,
  output logic [NUM_FAULTS-1:0] viewOut,
  output logic [NUM_FAULTS-1:0] stickyOut
);
  logic [NUM_FAULTS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_FAULTS-1:0] adjLevel;
  logic [NUM_FAULTS-1:0] stickyQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= faultRaw;
        else syncQ[s] <= syncQ[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign adjLevel = syncQ[SYNC_STAGES-1] ^ faultInvert;

  // clear first, then set, so a set in the same cycle wins
  generate
    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stickyQ[i] <= 1'b0;
        else stickyQ[i] <= (stickyQ[i] && !(ctrl.clrStrobe && clrMask[i])) || adjLevel[i];
      end
    end
  endgenerate

  assign viewOut   = ctrl.showSticky ? stickyQ : adjLevel;
  assign stickyOut = stickyQ;

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.clrStrobe |=> ((stickyQ & $past(stickyQ)) == $past(stickyQ)));
  // R6
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrStrobe |=> ((stickyQ & $past(clrMask & ~adjLevel)) == '0));
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adjLevel != '0) |=> ((stickyQ & $past(adjLevel)) == $past(adjLevel)));
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fsr_pkg::*;
#(
  parameter int NUM_FAULTS  = 4,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h04
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  wrEn,
  output logic [DATA_W-1:0]     rdData,
  input  logic [NUM_FAULTS-1:0] faultRaw,
  input  logic [NUM_FAULTS-1:0] faultInvert,
  input  logic                  latchMode,
  input  logic                  extEnable
);
  localparam int PAD_W = DATA_W - NUM_FAULTS;

  fsrCtrl_t              ctrl;
  logic [NUM_FAULTS-1:0] view;
  logic [NUM_FAULTS-1:0] sticky;

  fsr_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .addr(addr), .wrEn(wrEn), .latchMode(latchMode),
    .extEnable(extEnable), .ctrl(ctrl)
  );

  fsr_datapath #(.NUM_FAULTS(NUM_FAULTS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .faultRaw(faultRaw), .faultInvert(faultInvert),
    .clrMask(wrData[NUM_FAULTS-1:0]), .ctrl(ctrl),
    .viewOut(view), .stickyOut(sticky)
  );

  assign rdData = ctrl.addrHit ? {{PAD_W{1'b0}}, view} : '0;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:NUM_FAULTS] == '0);
  // R7
  gated_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !extEnable |=> ((sticky & $past(sticky)) == $past(sticky)));
endmodule

// File: tb/fault_status_reg_tb.sv
module fault_status_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = 8'h04;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic [31:0] rdData;
  logic [3:0]  faultRaw = '0;
  logic [3:0]  faultInvert = '0;
  logic        latchMode = 1'b0;
  logic        extEnable = 1'b0;

  int    checks = 0;
  int    failures = 0;
  string curReq = "R1";
  bit    finished = 1'b0;

  // behavioural model state
  logic [3:0] rawHist[$] = '{4'h0, 4'h0};
  logic [3:0] mSticky = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_status_reg u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .faultRaw(faultRaw), .faultInvert(faultInvert),
    .latchMode(latchMode), .extEnable(extEnable)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawHist = '{4'h0, 4'h0};
      mSticky = '0;
    end else begin
      logic [3:0] seen;
      seen = rawHist[0] ^ faultInvert;
      if (wrEn && addr == 8'h04 && extEnable && latchMode)
        mSticky = mSticky & ~wrData[3:0];
      mSticky = mSticky | seen;
      void'(rawHist.pop_front());
      rawHist.push_back(faultRaw);
    end
  end

  function automatic logic [31:0] expected();
    logic [3:0] live;
    live = rawHist[0] ^ faultInvert;
    if (addr != 8'h04) return '0;
    return {28'h0, latchMode ? mSticky : live};
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      logic [31:0] exp;
      exp = expected();
      checks++;
      if (rdData !== exp) begin
        failures++;
        $display("FAIL %s rdData=%h expected=%h at %0t", curReq, rdData, exp, $time);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doWrite(logic [31:0] d);
    wrData = d; wrEn = 1'b1;
    tick(1);
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    curReq = "R1"; tick(3); rstN = 1'b1; tick(2);
    // R3 live levels follow after two edges
    curReq = "R3"; faultRaw = 4'b0101; tick(4); faultRaw = 4'b0010; tick(4);
    // R4 invert bits flip sense immediately
    curReq = "R4"; faultInvert = 4'b1111; tick(1); faultInvert = 4'b1001; tick(3);
    faultInvert = 4'b0000; faultRaw = 4'b0000; tick(4);
    // R9 fault seen in live mode, revealed in sticky mode
    curReq = "R9"; latchMode = 1'b1; extEnable = 1'b1; doWrite(32'hF); tick(2);
    latchMode = 1'b0; faultRaw = 4'b1000; tick(1); faultRaw = 4'b0000; tick(4);
    latchMode = 1'b1; tick(2);
    // R5 flag held after input drops
    curReq = "R5"; faultRaw = 4'b0001; tick(1); faultRaw = 4'b0000; tick(5);
    // R6 write-1 clears, write-0 keeps
    curReq = "R6"; doWrite(32'h0); tick(1); doWrite(32'h8); tick(2);
    doWrite(32'hFFFF_FFF0); tick(1); doWrite(32'h1); tick(2);
    // R7 gated writes
    curReq = "R7"; faultRaw = 4'b0110; tick(1); faultRaw = 4'b0000; tick(4);
    extEnable = 1'b0; doWrite(32'hF); tick(2); extEnable = 1'b1;
    // R10 writes in live mode do nothing to flags
    curReq = "R10"; latchMode = 1'b0; doWrite(32'hF); tick(1);
    latchMode = 1'b1; tick(2); doWrite(32'hF); tick(2);
    // R8 set beats clear in the same cycle
    curReq = "R8"; faultRaw = 4'b0100; tick(4); doWrite(32'h4); tick(1);
    faultRaw = 4'b0000; tick(3); doWrite(32'h4); tick(2);
    faultRaw = 4'b0010; tick(2); doWrite(32'h2); faultRaw = 4'b0000; tick(3);
    doWrite(32'hF); tick(1);
    // R2 reserved bits and foreign addresses
    curReq = "R2"; faultRaw = 4'b1111; tick(4); addr = 8'h00; tick(2);
    addr = 8'h08; doWrite(32'hF); addr = 8'h04; tick(2);
    faultRaw = 4'b0000; latchMode = 1'b0; tick(4);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule